// File: doc/BRIEF.md
# Pipelined-Address Bus Cycle Controller

This block is the bus-master end of a processor's external bus. An internal requester offers one bus operation at a time: address, byte enables, a write flag and write data. The controller runs it as a read or write bus cycle. It drives an active-low address strobe together with the address, byte enables and write/read indicator. It enables the write-data drivers, and it hands read data and a one-clock completion pulse back to the requester. The system answers with an active-low ready and may assert an active-low next-address input. That input asks for the address of the following cycle to be put out before the current cycle has finished.

The controller has six states. Idle `S_TI` has no cycle open. The first state `S_T1` of a non-pipelined cycle is where the strobe is driven. The second state `S_T2` repeats for every wait state. Three states serve overlapped addressing. In `S_T2P` the current cycle is still waiting for ready while the next address is already on the bus. `S_T1P` is the first data clock of a cycle whose address went out early. In `S_T2I` overlap has been granted but no request is waiting yet.

Transitions:
- TI→T1 when a request is present.
- T1→T2 always.
- T2→T1 or T2→TI when ready arrives, depending on whether a request waits.
- T2→T2P when the cycle waits with next-address asserted and a request present.
- T2→T2I under the same conditions without a request.
- T2I→T2P when a request arrives while waiting.
- T2I→T1 or T2I→TI when ready arrives.
- T2P→T1P when ready arrives.
- T1P→T2P when next-address is asserted and a request is present.
- T1P→T2I when next-address is asserted and no request is present.
- T1P→T2 when next-address is not asserted.

Bus cycles after an idle clock always start non-pipelined. Once overlap is established, a stream of cycles costs two clocks each, T1P then T2P.

Top module: `pipe_bus_ctrl`

## Requirements
- R1: While reset is held, and on the first clock after it, `ads_n` is high and `req_done`, `bus_den` and `req_take` are low.
- R2: In idle, a high `req_valid` gives `req_take` high in that same clock. On the next clock `ads_n` is low and `bus_addr`, `bus_be` and `bus_wr` carry that request. This is the non-pipelined T1, and T2 follows it.
- R3: `rdy_n` low is sampled at a clock edge in T2, T2I or T2P. At that edge it ends the open cycle. For a read, `bus_din` is captured into `req_rdata`.
- R4: `rdy_n` is ignored in TI, T1 and T1P. `na_n` has no effect when the T2 clock ends with ready. Zero-wait cycles therefore stay non-pipelined with `na_n` held low, and their strobes come exactly two clocks apart.
- R5: A T2 clock may end with `rdy_n` high, `na_n` low and a request present. The request is then taken, and the next clock (T2P) shows `ads_n` low with the new address while the earlier cycle is still open.
- R6: T2P repeats on every clock in which `rdy_n` is high. `ads_n` is low only on the first T2P clock.
- R7: Ready in T2P leads to T1P. If T1P sees `na_n` low and a request, T2P follows. Overlapped cycles then put out a strobe every two clocks, and at most two cycles are ever open.
- R8: A T2 wait with `na_n` low and no request leads to T2I. A request arriving in T2I before ready is taken as an overlapped (T2P) cycle. Ready in T2I with no request returns to idle, so the next cycle is non-pipelined.
- R9: `bus_den` is high, and `bus_dout` equals the write data, in every clock from a write cycle's first data clock (T1 or T1P) through the clock its ready is sampled. `bus_den` is low when no cycle is open.
- R10: `ads_n` is never low for two clocks running. `bus_addr`, `bus_be` and `bus_wr` hold their value in every clock in which `ads_n` is high.
- R11: Each completed cycle gives exactly one `req_done` pulse, one clock long, on the clock after its ready. Completions come in the order the requests were taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Requester has an operation to run |
| req_addr | input | AW | Address of the offered operation |
| req_be | input | DW/8 | Byte enables of the offered operation |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data of the offered operation |
| req_take | output | 1 | Offered operation is accepted at this clock edge |
| req_done | output | 1 | One-clock pulse: oldest open cycle completed |
| req_rdata | output | DW | Read data of the last completed read |
| na_n | input | 1 | Active-low next-address request from the system |
| rdy_n | input | 1 | Active-low ready ending the current cycle |
| ads_n | output | 1 | Active-low address strobe |
| bus_addr | output | AW | Bus address |
| bus_be | output | DW/8 | Bus byte enables |
| bus_wr | output | 1 | Write/read indicator of the addressed cycle |
| bus_den | output | 1 | Write-data driver enable |
| bus_dout | output | DW | Write data onto the bus |
| bus_din | input | DW | Read data from the bus |

## Verification
The hardest situation to reach is the pipelined-idle state. To get there, a cycle must be held in wait states with next-address asserted while the requester is deliberately silent. A request must then appear before ready, and in a second run ready must arrive first. A directed sequence controls the ready, next-address and request-valid knobs clock by clock to force both endings. Random traffic mixes waits, next-address and request gaps to reach the T1P/T2P loop and its exits. A bus-side model ages each open cycle, so ready is offered only where it may be sampled and is given random junk values elsewhere.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
    typedef enum logic [2:0] {
        S_TI  = 3'd0,
        S_T1  = 3'd1,
        S_T2  = 3'd2,
        S_T2I = 3'd3,
        S_T2P = 3'd4,
        S_T1P = 3'd5
    } bus_st_e;
endpackage

// File: rtl/pbc_fsm.sv
module pbc_fsm
    import pbc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  logic    na_n,
    input  logic    rdy_n,
    output bus_st_e st,
    output logic    take,
    output logic    load_cur,
    output logic    load_pend,
    output logic    promote,
    output logic    cyc_end,
    output logic    active,
    output logic    ads_n
);
    bus_st_e nxt;
    logic    ads_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= S_TI;
            ads_q <= 1'b0;
        end else begin
            st    <= nxt;
            ads_q <= (nxt == S_T1) || (nxt == S_T2P && st != S_T2P);
        end
    end

    // next state and strobes
    always_comb begin
        nxt       = st;
        take      = 1'b0;
        load_cur  = 1'b0;
        load_pend = 1'b0;
        promote   = 1'b0;
        cyc_end   = 1'b0;
        unique case (st)
            S_TI: begin
                if (req_valid) begin
                    nxt      = S_T1;
                    take     = 1'b1;
                    load_cur = 1'b1;
                end
            end
            S_T1: nxt = S_T2;
            S_T2, S_T2I: begin
                if (!rdy_n) begin
                    cyc_end = 1'b1;
                    if (req_valid) begin
                        nxt      = S_T1;
                        take     = 1'b1;
                        load_cur = 1'b1;
                    end else begin
                        nxt = S_TI;
                    end
                end else if (st == S_T2I || !na_n) begin
                    if (req_valid) begin
                        nxt       = S_T2P;
                        take      = 1'b1;
                        load_pend = 1'b1;
                    end else begin
                        nxt = S_T2I;
                    end
                end
            end
            S_T2P: begin
                if (!rdy_n) begin
                    cyc_end = 1'b1;
                    promote = 1'b1;
                    nxt     = S_T1P;
                end
            end
            S_T1P: begin
                if (!na_n) begin
                    if (req_valid) begin
                        nxt       = S_T2P;
                        take      = 1'b1;
                        load_pend = 1'b1;
                    end else begin
                        nxt = S_T2I;
                    end
                end else begin
                    nxt = S_T2;
                end
            end
            default: nxt = S_TI;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        active = (st != S_TI);
        ads_n  = ~ads_q;
    end

    // R2
    idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_TI) |=> (st == S_TI || st == S_T1));
    // R10
    ads_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n |=> ads_n);
    // R6
    t2p_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_T2P && rdy_n) |=> (st == S_T2P && ads_n));
    // R7
    t1p_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_T1P) |-> ($past(st) == S_T2P && !$past(rdy_n)));
endmodule

// File: rtl/pbc_addr_stage.sv
module pbc_addr_stage #(
    parameter int AW = 24,
    parameter int BW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          ads_n,
    input  logic [AW-1:0] req_addr,
    input  logic [BW-1:0] req_be,
    input  logic          req_write,
    output logic [AW-1:0] bus_addr,
    output logic [BW-1:0] bus_be,
    output logic          bus_wr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_addr <= '0;
            bus_be   <= '0;
            bus_wr   <= 1'b0;
        end else if (load) begin
            bus_addr <= req_addr;
            bus_be   <= req_be;
            bus_wr   <= req_write;
        end
    end

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ads_n |-> $stable({bus_addr, bus_be, bus_wr}));
endmodule

// File: rtl/pbc_data_stage.sv
module pbc_data_stage #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_cur,
    input  logic          load_pend,
    input  logic          promote,
    input  logic          cyc_end,
    input  logic          active,
    input  logic          req_write,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] bus_din,
    output logic          bus_den,
    output logic [DW-1:0] bus_dout,
    output logic [DW-1:0] rd_data,
    output logic          done
);
    logic          cur_wr, pend_wr;
    logic [DW-1:0] cur_wd, pend_wd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_wr  <= 1'b0;
            cur_wd  <= '0;
            pend_wr <= 1'b0;
            pend_wd <= '0;
            rd_data <= '0;
            done    <= 1'b0;
        end else begin
            if (load_cur) begin
                cur_wr <= req_write;
                cur_wd <= req_wdata;
            end else if (promote) begin
                cur_wr <= pend_wr;
                cur_wd <= pend_wd;
            end
            if (load_pend) begin
                pend_wr <= req_write;
                pend_wd <= req_wdata;
            end
            if (cyc_end && !cur_wr) rd_data <= bus_din;
            done <= cyc_end;
        end
    end

    always_comb begin
        bus_den  = active & cur_wr;
        bus_dout = bus_den ? cur_wd : '0;
    end

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    den_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !bus_den);
endmodule

// File: rtl/pipe_bus_ctrl.sv
module pipe_bus_ctrl
    import pbc_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [AW-1:0]      req_addr,
    input  logic [DW/8-1:0]    req_be,
    input  logic               req_write,
    input  logic [DW-1:0]      req_wdata,
    output logic               req_take,
    output logic               req_done,
    output logic [DW-1:0]      req_rdata,
    input  logic               na_n,
    input  logic               rdy_n,
    output logic               ads_n,
    output logic [AW-1:0]      bus_addr,
    output logic [DW/8-1:0]    bus_be,
    output logic               bus_wr,
    output logic               bus_den,
    output logic [DW-1:0]      bus_dout,
    input  logic [DW-1:0]      bus_din
);
    localparam int BW = DW / 8;

    bus_st_e st;
    logic    take, load_cur, load_pend, promote, cyc_end, active;

    pbc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .na_n      (na_n),
        .rdy_n     (rdy_n),
        .st        (st),
        .take      (take),
        .load_cur  (load_cur),
        .load_pend (load_pend),
        .promote   (promote),
        .cyc_end   (cyc_end),
        .active    (active),
        .ads_n     (ads_n)
    );

    pbc_addr_stage #(.AW(AW), .BW(BW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take),
        .ads_n     (ads_n),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .req_write (req_write),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wr    (bus_wr)
    );

    pbc_data_stage #(.DW(DW)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_cur  (load_cur),
        .load_pend (load_pend),
        .promote   (promote),
        .cyc_end   (cyc_end),
        .active    (active),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .bus_din   (bus_din),
        .bus_den   (bus_den),
        .bus_dout  (bus_dout),
        .rd_data   (req_rdata),
        .done      (req_done)
    );

    assign req_take = take;

    // R5
    take_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_take |-> req_valid);
    // R2
    take_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_take |=> !ads_n);
endmodule

// File: tb/pipe_bus_ctrl_tb.sv
`timescale 1ns/100ps
module pipe_bus_ctrl_tb;
    localparam int AW = 24;
    localparam int DW = 32;
    localparam int BW = DW / 8;

    typedef struct packed {
        logic [AW-1:0] a;
        logic [BW-1:0] be;
        logic          wr;
        logic [DW-1:0] wd;
    } rq_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [BW-1:0] req_be = '0;
    logic          req_write = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_take, req_done;
    logic [DW-1:0] req_rdata;
    logic          na_n = 1'b1;
    logic          rdy_n = 1'b1;
    logic          ads_n;
    logic [AW-1:0] bus_addr;
    logic [BW-1:0] bus_be;
    logic          bus_wr, bus_den;
    logic [DW-1:0] bus_dout;
    logic [DW-1:0] bus_din = '0;

    pipe_bus_ctrl #(.AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_be(req_be), .req_write(req_write), .req_wdata(req_wdata),
        .req_take(req_take), .req_done(req_done), .req_rdata(req_rdata),
        .na_n(na_n), .rdy_n(rdy_n), .ads_n(ads_n), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wr(bus_wr), .bus_den(bus_den),
        .bus_dout(bus_dout), .bus_din(bus_din)
    );

    always #2.5 clk = ~clk;

    int  checks = 0, errors = 0;
    rq_t cur_rq, took_rq;
    rq_t ob_q[$];
    logic prev_take = 1'b0, prev_end = 1'b0;
    int  age = 0;
    int  p_rdy = 100, p_na = 0, p_req = 0, min_age = 1, ov_rdy = 2;
    bit  warm = 1'b0;
    int  ads_cnt = 0, pipe_cnt = 0, done_cnt = 0, last_ads = -10, bad_gap = 0, clk_cnt = 0;
    bit  done_flag = 1'b0;

    function automatic logic [DW-1:0] rdf(logic [AW-1:0] a);
        return {a[15:0] ^ 16'h5a3c, ~a[15:0]};
    endfunction

    function automatic rq_t mk_rq();
        rq_t r;
        r.a  = AW'($urandom);
        r.be = BW'($urandom_range(1, (1 << BW) - 1));
        r.wr = 1'($urandom_range(0, 1));
        r.wd = DW'($urandom);
        return r;
    endfunction

    task automatic chk(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic tick();
        bit elig, want;
        @(negedge clk);
        clk_cnt++;
        if (prev_end) begin
            rq_t o = ob_q.pop_front();
            chk(req_done == 1'b1, "R11", "done pulse", 64'(req_done), 64'd1);
            done_cnt++;
            if (!o.wr) chk(req_rdata == rdf(o.a), "R3", "read data", 64'(req_rdata), 64'(rdf(o.a)));
            if (ob_q.size() > 0) age = 0;
        end else begin
            chk(req_done == 1'b0, "R11", "no done", 64'(req_done), 64'd0);
            if (ob_q.size() > 0) age++;
        end
        // R2 R5: strobe exactly one clock after a take
        chk(ads_n == !prev_take, (ob_q.size() > 0) ? "R5" : "R2", "strobe timing", 64'(ads_n), 64'(!prev_take));
        if (!ads_n) begin
            chk({bus_addr, bus_be, bus_wr} == {took_rq.a, took_rq.be, took_rq.wr}, "R10",
                "address phase", 64'({bus_addr, bus_be, bus_wr}), 64'({took_rq.a, took_rq.be, took_rq.wr}));
            if (clk_cnt - last_ads != 2 && warm) bad_gap++;
            last_ads = clk_cnt;
            ads_cnt++;
            if (ob_q.size() > 0) pipe_cnt++;
            else age = 0;
            ob_q.push_back(took_rq);
            chk(ob_q.size() <= 2, "R7", "open cycles", 64'(ob_q.size()), 64'd2);
        end
        if (ob_q.size() > 0) begin
            chk(bus_den == ob_q[0].wr, "R9", "data enable", 64'(bus_den), 64'(ob_q[0].wr));
            if (ob_q[0].wr) chk(bus_dout == ob_q[0].wd, "R9", "write data", 64'(bus_dout), 64'(ob_q[0].wd));
        end else begin
            chk(bus_den == 1'b0, "R9", "idle enable", 64'(bus_den), 64'd0);
        end
        // drive inputs
        elig = (ob_q.size() > 0) && (age >= 1);
        if (ov_rdy == 1) want = elig;
        else if (ov_rdy == 0) want = 1'b0;
        else want = elig && (age >= min_age) && ($urandom_range(99) < p_rdy);
        rdy_n    = elig ? !want : 1'($urandom_range(0, 1));   // R4: junk where ready is ignored
        prev_end = want;
        bus_din  = (want && !ob_q[0].wr) ? rdf(ob_q[0].a) : DW'($urandom);
        na_n     = !($urandom_range(99) < p_na);
        if (prev_take) req_valid = 1'b0;
        if (!req_valid && ($urandom_range(99) < p_req)) begin
            cur_rq    = mk_rq();
            req_valid = 1'b1;
            req_addr  = cur_rq.a;
            req_be    = cur_rq.be;
            req_write = cur_rq.wr;
            req_wdata = cur_rq.wd;
        end
        #1;
        prev_take = req_take;
        if (req_take) took_rq = cur_rq;
    endtask

    task automatic drain();
        p_req = 0; ov_rdy = 1; warm = 1'b0;
        repeat (12) tick();
        ov_rdy = 2;
    endtask

    initial begin
        int base_pipe, base_ads;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1
        chk(ads_n == 1'b1, "R1", "reset strobe", 64'(ads_n), 64'd1);
        chk(req_done == 1'b0, "R1", "reset done", 64'(req_done), 64'd0);
        chk(bus_den == 1'b0, "R1", "reset enable", 64'(bus_den), 64'd0);
        chk(req_take == 1'b0, "R1", "reset take", 64'(req_take), 64'd0);
        rst_n = 1'b1;
        repeat (2) tick();

        // R4: zero wait with NA always asserted stays non-pipelined
        p_rdy = 100; p_na = 100; p_req = 100; min_age = 1;
        base_pipe = pipe_cnt; base_ads = ads_cnt;
        tick(); tick(); warm = 1'b1; bad_gap = 0;
        repeat (40) tick();
        chk(pipe_cnt == base_pipe, "R4", "no overlap on zero-wait", 64'(pipe_cnt - base_pipe), 64'd0);
        chk(bad_gap == 0, "R4", "strobe spacing", 64'(bad_gap), 64'd0);
        chk(ads_cnt - base_ads >= 19, "R4", "strobe count", 64'(ads_cnt - base_ads), 64'd20);
        drain();

        // R7: one wait to enter overlap, then two-clock cycles
        p_na = 100; p_req = 100; min_age = 2; p_rdy = 100;
        base_pipe = pipe_cnt; base_ads = ads_cnt;
        while (pipe_cnt == base_pipe) tick();
        min_age = 1; warm = 1'b1; bad_gap = 0; last_ads = clk_cnt;
        base_ads = ads_cnt; base_pipe = pipe_cnt;
        repeat (40) tick();
        chk(bad_gap == 0, "R7", "overlapped spacing", 64'(bad_gap), 64'd0);
        chk(pipe_cnt - base_pipe == ads_cnt - base_ads, "R7", "all overlapped",
            64'(pipe_cnt - base_pipe), 64'(ads_cnt - base_ads));
        drain();

        // R8 / R6: T2I then request, long T2P wait
        base_pipe = pipe_cnt;
        p_na = 0; ov_rdy = 0; p_req = 100;
        tick();                    // TI: take
        p_req = 0; tick();         // T1
        p_na = 100; tick();        // T2 wait, NA -> T2I
        tick(); tick();            // T2I
        p_req = 100; tick();       // T2I: take -> T2P
        p_req = 0; p_na = 0;
        repeat (4) tick();         // T2P repeats (R6)
        ov_rdy = 1; tick();        // T2P ends -> T1P
        tick(); tick(); tick();
        chk(pipe_cnt - base_pipe == 1, "R8", "request in T2I overlaps", 64'(pipe_cnt - base_pipe), 64'd1);
        drain();

        // R8: T2I ended by ready returns to idle
        base_pipe = pipe_cnt;
        p_na = 0; ov_rdy = 0; p_req = 100;
        tick();
        p_req = 0; tick();
        p_na = 100; tick();
        tick();
        ov_rdy = 1; p_na = 0; tick();
        tick();
        p_req = 100; tick();
        p_req = 0; tick(); tick(); tick(); tick();
        chk(pipe_cnt == base_pipe, "R8", "T2I to idle restarts non-pipelined", 64'(pipe_cnt - base_pipe), 64'd0);
        drain();

        // random traffic (R3 R5 R6 R7 R9 R10 R11)
        p_rdy = 45; p_na = 50; p_req = 60; min_age = 1; ov_rdy = 2;
        repeat (4000) tick();
        drain();
        chk(done_cnt == ads_cnt, "R11", "completions match strobes", 64'(done_cnt), 64'(ads_cnt));
        chk(pipe_cnt > 20, "R5", "overlap reached", 64'(pipe_cnt), 64'd21);

        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule